// File: doc/BRIEF.md
# E1 CRC-4 Interworking Alignment Controller

This block decides, on an E1 receiver, whether the far end sends CRC-4 multiframes, and which basic-frame position the receiver should follow. Alignment detection is done outside the block. The block reacts to three kinds of event:

- a primary basic alignment, with its bit offset;
- alternative basic alignments, each with its bit offset;
- multiframe-found events, each tagged with the candidate slot it belongs to.

The block counts frame strobes from the moment the primary position is established. After a short window without multiframe lock, it opens a parallel search. During that search, further basic alignments are stored as candidates, and the receiver stays locked to the primary position.

If a multiframe is found on any stored candidate before the long window expires, the link is declared CRC-4. The selected offset moves to that candidate, and CRC checking is enabled. If the long window expires first, the block falls back to plain doubleframe operation and keeps the primary offset. In that case it raises a sticky status and a one-cycle interrupt, disables CRC checking and forces received E-bits low. An extended-interworking control suppresses the fallback, so the search continues for as long as it is set.

Top module: `e1_mf_interwork`

## Requirements
- R1: After reset all outputs are 0. In the idle state, `prim_found` stores `prim_off` in slot 0, sets `sel_off` to it one cycle later, and starts the search with the frame counter at 0.
- R2: During the search, `par_act` rises at the clock where the SHORT_FR-th (64th) frame tick is counted. Before that, `alt_found` is ignored.
- R3: While `par_act` is high, each `alt_found` stores `alt_off` in the lowest free slot, from 1 to NCAND-1 (1 to 3). With all slots in use, further `alt_found` events are ignored and the stored offsets stay unchanged.
- R4: During the search, `mf_found` whose `mf_tag` names a filled slot (tag 0 is the primary) locks the block. One cycle later, `sel_off` equals that slot's offset, `crc_chk_en` is 1, `ebit_low` is 0 and `par_act` is 0. A tag naming an empty slot is ignored.
- R5: When the LONG_FR-th (3200th) frame tick of a search arrives without lock while `ext_iw` is 0, the block falls back. One cycle later, `nomf` is 1, `tmo_irq` is 1 for exactly one cycle, `ebit_low` is 1, `crc_chk_en` is 0, `par_act` is 0, and `sel_off` keeps the primary offset.
- R6: While `ext_iw` is 1, the long window causes no fallback, and the search with `par_act` continues. If `ext_iw` is cleared after the window has passed, the next frame tick causes the fallback.
- R7: `perf_on` is 1 exactly when `crc_chk_en` and `perf_en` are both 1. It follows `perf_en` in the same cycle.
- R8: `bfa_lost` overrides every other input. One cycle later, the block is idle, all slots are empty, and `sel_off`, `nomf`, `par_act`, `crc_chk_en` and `ebit_low` are 0.
- R9: A valid `mf_found` in the same cycle as the timeout tick wins: the block locks, and `nomf` and `tmo_irq` stay 0.
- R10: Once locked or fallen back, the block ignores `prim_found`, `alt_found`, `mf_found` and frame ticks until `bfa_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe per 125 us frame |
| bfa_lost | input | 1 | Loss of basic frame alignment |
| prim_found | input | 1 | Primary basic alignment established |
| prim_off | input | OFFW | Bit offset of the primary alignment |
| alt_found | input | 1 | Parallel search found a basic alignment |
| alt_off | input | OFFW | Bit offset of that alignment |
| mf_found | input | 1 | Multiframe alignment found |
| mf_tag | input | clog2(NCAND) | Candidate slot the multiframe belongs to |
| ext_iw | input | 1 | Suppress the long-window fallback |
| perf_en | input | 1 | Enable for performance monitoring |
| sel_off | output | OFFW | Alignment offset the receiver follows |
| par_act | output | 1 | Parallel basic-alignment search running |
| crc_chk_en | output | 1 | CRC-4 checking enabled (multiframe locked) |
| ebit_low | output | 1 | Force received E-bits low (fallback) |
| perf_on | output | 1 | Performance monitoring active |
| nomf | output | 1 | Sticky: no multiframe found |
| tmo_irq | output | 1 | One-cycle interrupt at fallback |

## Verification
A wrong frame count shows as `par_act` rising, or `nomf` and `tmo_irq` appearing, one or more ticks away from ticks 64 and 3200. The bench counts these ticks exactly, so a count that is off by one shows at the port in the cycle it happens. A corrupted candidate table shows only when a multiframe event selects a slot, through a wrong `sel_off` one cycle after that event. The bench therefore makes a selection after filling the table, and after attempting a premature store. A wrong state shows at once on `crc_chk_en` and `ebit_low`, which are decoded directly from it.

// File: rtl/e1_mf_interwork.sv
module e1_mf_interwork #(
  parameter int OFFW     = 8,
  parameter int NCAND    = 4,
  parameter int SHORT_FR = 64,
  parameter int LONG_FR  = 3200,
  localparam int TAGW    = $clog2(NCAND),
  localparam int CNTW    = $clog2(LONG_FR + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_tick,
  input  logic            bfa_lost,
  input  logic            prim_found,
  input  logic [OFFW-1:0] prim_off,
  input  logic            alt_found,
  input  logic [OFFW-1:0] alt_off,
  input  logic            mf_found,
  input  logic [TAGW-1:0] mf_tag,
  input  logic            ext_iw,
  input  logic            perf_en,
  output logic [OFFW-1:0] sel_off,
  output logic            par_act,
  output logic            crc_chk_en,
  output logic            ebit_low,
  output logic            perf_on,
  output logic            nomf,
  output logic            tmo_irq
);

  typedef enum logic [1:0] {S_IDLE, S_SRCH, S_CRC4, S_NOCRC} st_t;

  st_t             st;
  logic [OFFW-1:0] cand [NCAND];
  logic [NCAND-1:0] vld;
  logic [CNTW-1:0] fcnt;

  logic            have_free;
  logic [TAGW-1:0] free_idx;
  logic            mf_ok, tmo_hit, in_srch;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = NCAND - 1; i >= 1; i--) begin
      if (!vld[i]) begin
        have_free = 1'b1;
        free_idx  = TAGW'(i);
      end
    end
  end

  assign in_srch = (st == S_SRCH);
  assign mf_ok   = in_srch && mf_found && (int'(mf_tag) < NCAND) && vld[mf_tag];
  assign tmo_hit = in_srch && frame_tick && !ext_iw && (fcnt >= CNTW'(LONG_FR - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || bfa_lost) begin
      st      <= S_IDLE;
      vld     <= '0;
      fcnt    <= '0;
      sel_off <= '0;
      par_act <= 1'b0;
      nomf    <= 1'b0;
      tmo_irq <= 1'b0;
      for (int i = 0; i < NCAND; i++) cand[i] <= '0;
    end else begin
      tmo_irq <= 1'b0;
      case (st)
        S_IDLE: if (prim_found) begin
          st      <= S_SRCH;
          cand[0] <= prim_off;
          vld     <= NCAND'(1);
          sel_off <= prim_off;
          fcnt    <= '0;
        end
        S_SRCH: begin
          if (mf_ok) begin
            st      <= S_CRC4;
            sel_off <= cand[mf_tag];
            par_act <= 1'b0;
          end else if (tmo_hit) begin
            st      <= S_NOCRC;
            nomf    <= 1'b1;
            tmo_irq <= 1'b1;
            par_act <= 1'b0;
          end else begin
            if (frame_tick && fcnt != CNTW'(LONG_FR)) fcnt <= fcnt + 1'b1;
            if (frame_tick && fcnt == CNTW'(SHORT_FR - 1)) par_act <= 1'b1;
            if (alt_found && par_act && have_free) begin
              cand[free_idx] <= alt_off;
              vld[free_idx]  <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign crc_chk_en = (st == S_CRC4);
  assign ebit_low   = (st == S_NOCRC);
  assign perf_on    = crc_chk_en && perf_en;

endmodule

// File: rtl/e1_mf_interwork_chk.sv
module e1_mf_interwork_chk #(
  parameter int OFFW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bfa_lost,
  input logic            perf_en,
  input logic [OFFW-1:0] sel_off,
  input logic            par_act,
  input logic            crc_chk_en,
  input logic            ebit_low,
  input logic            perf_on,
  input logic            nomf,
  input logic            tmo_irq
);

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_chk_en && ebit_low)); // R4

  AST_PAR_ONLY_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    par_act |-> !crc_chk_en && !ebit_low); // R2

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |=> !tmo_irq); // R5

  AST_IRQ_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |-> nomf && ebit_low); // R5

  AST_NOMF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    nomf && !bfa_lost |=> nomf); // R5

  AST_LOST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bfa_lost |=> !nomf && !crc_chk_en && !ebit_low && !par_act && sel_off == '0); // R8

  AST_PERF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    perf_on |-> crc_chk_en && perf_en); // R7

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    crc_chk_en && !bfa_lost |=> crc_chk_en && $stable(sel_off)); // R10

endmodule

bind e1_mf_interwork e1_mf_interwork_chk #(.OFFW(OFFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bfa_lost(bfa_lost), .perf_en(perf_en),
  .sel_off(sel_off), .par_act(par_act), .crc_chk_en(crc_chk_en),
  .ebit_low(ebit_low), .perf_on(perf_on), .nomf(nomf), .tmo_irq(tmo_irq)
);

// File: tb/sim_e1_mf_interwork.sv
module sim_e1_mf_interwork;
  localparam int OFFW = 8;
  localparam int TAGW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 0, bfa_lost = 0, prim_found = 0, alt_found = 0, mf_found = 0;
  logic ext_iw = 0, perf_en = 0;
  logic [OFFW-1:0] prim_off = '0, alt_off = '0;
  logic [TAGW-1:0] mf_tag = '0;
  logic [OFFW-1:0] sel_off;
  logic par_act, crc_chk_en, ebit_low, perf_on, nomf, tmo_irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  e1_mf_interwork u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .bfa_lost(bfa_lost),
    .prim_found(prim_found), .prim_off(prim_off), .alt_found(alt_found),
    .alt_off(alt_off), .mf_found(mf_found), .mf_tag(mf_tag), .ext_iw(ext_iw),
    .perf_en(perf_en), .sel_off(sel_off), .par_act(par_act),
    .crc_chk_en(crc_chk_en), .ebit_low(ebit_low), .perf_on(perf_on),
    .nomf(nomf), .tmo_irq(tmo_irq)
  );

  // ops: 0 lose, 1 primary, 2 alternative, 3 multiframe, 4 ticks
  // fields: op[41:39] off[38:31] tag[30:29] cnt[28:13] exp_off[12:5] flags[4:0]
  // flags = {crc_chk_en, ebit_low, nomf, par_act, tmo_irq}
  localparam int NV = 15;
  localparam logic [41:0] VEC [NV] = '{
    {3'd0, 8'd0,  2'd0, 16'd0,    8'd0,  5'b00000}, // R8
    {3'd1, 8'd10, 2'd0, 16'd0,    8'd10, 5'b00000}, // R1
    {3'd2, 8'd33, 2'd0, 16'd0,    8'd10, 5'b00000}, // R2 early alt ignored
    {3'd4, 8'd0,  2'd0, 16'd63,   8'd10, 5'b00000}, // R2
    {3'd4, 8'd0,  2'd0, 16'd1,    8'd10, 5'b00010}, // R2
    {3'd2, 8'd50, 2'd0, 16'd0,    8'd10, 5'b00010}, // R3
    {3'd2, 8'd90, 2'd0, 16'd0,    8'd10, 5'b00010}, // R3
    {3'd3, 8'd0,  2'd2, 16'd0,    8'd90, 5'b10000}, // R4
    {3'd4, 8'd0,  2'd0, 16'd4000, 8'd90, 5'b10000}, // R10
    {3'd0, 8'd0,  2'd0, 16'd0,    8'd0,  5'b00000}, // R8
    {3'd1, 8'd7,  2'd0, 16'd0,    8'd7,  5'b00000}, // R1
    {3'd4, 8'd0,  2'd0, 16'd3199, 8'd7,  5'b00010}, // R5
    {3'd4, 8'd0,  2'd0, 16'd1,    8'd7,  5'b01101}, // R5
    {3'd3, 8'd0,  2'd0, 16'd0,    8'd7,  5'b01100}, // R10
    {3'd0, 8'd0,  2'd0, 16'd0,    8'd0,  5'b00000}  // R8
  };
  localparam string VREQ [NV] = '{"R8","R1","R2","R2","R2","R3","R3","R4",
                                  "R10","R8","R1","R5","R5","R10","R8"};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(int op, logic [7:0] off, logic [1:0] tag, int cnt);
    case (op)
      0: begin bfa_lost = 1; @(negedge clk); bfa_lost = 0; end
      1: begin prim_off = off; prim_found = 1; @(negedge clk); prim_found = 0; end
      2: begin alt_off = off; alt_found = 1; @(negedge clk); alt_found = 0; end
      3: begin mf_tag = tag; mf_found = 1; @(negedge clk); mf_found = 0; end
      default: begin frame_tick = 1; repeat (cnt) @(negedge clk); frame_tick = 0; end
    endcase
  endtask

  function automatic logic [4:0] flags();
    return {crc_chk_en, ebit_low, nomf, par_act, tmo_irq};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", {sel_off, flags(), perf_on}, '0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      do_op(int'(VEC[v][41:39]), VEC[v][38:31], VEC[v][30:29], int'(VEC[v][28:13]));
      chk(VREQ[v], {sel_off, flags()}, {VEC[v][12:5], VEC[v][4:0]});
    end

    // R6 extended interworking: no fallback, then fallback after release
    ext_iw = 1;
    do_op(1, 8'd5, 2'd0, 0);
    do_op(4, 8'd0, 2'd0, 3300);
    chk("R6 held search", {sel_off, flags()}, {8'd5, 5'b00010});
    ext_iw = 0;
    do_op(4, 8'd0, 2'd0, 1);
    chk("R6 release", {sel_off, flags()}, {8'd5, 5'b01101});

    // R3 table full
    do_op(0, 8'd0, 2'd0, 0);
    do_op(1, 8'd1, 2'd0, 0);
    do_op(4, 8'd0, 2'd0, 64);
    do_op(2, 8'd11, 2'd0, 0);
    do_op(2, 8'd12, 2'd0, 0);
    do_op(2, 8'd13, 2'd0, 0);
    do_op(2, 8'd14, 2'd0, 0);
    do_op(3, 8'd0, 2'd3, 0);
    chk("R3 full ignored", {sel_off, flags()}, {8'd13, 5'b10000});

    // R4 empty slot tag ignored, then valid tag
    do_op(0, 8'd0, 2'd0, 0);
    do_op(1, 8'd2, 2'd0, 0);
    do_op(4, 8'd0, 2'd0, 64);
    do_op(2, 8'd20, 2'd0, 0);
    do_op(3, 8'd0, 2'd2, 0);
    chk("R4 empty tag", {sel_off, flags()}, {8'd2, 5'b00010});
    perf_en = 1; #1;
    chk("R7 off in search", {31'd0, perf_on}, 32'd0);
    do_op(3, 8'd0, 2'd1, 0);
    chk("R4 alt tag", {sel_off, flags()}, {8'd20, 5'b10000});
    chk("R7 on", {31'd0, perf_on}, 32'd1);
    perf_en = 0; #1;
    chk("R7 follow", {31'd0, perf_on}, 32'd0);

    // R9 lock wins over timeout tick
    do_op(0, 8'd0, 2'd0, 0);
    do_op(1, 8'd3, 2'd0, 0);
    do_op(4, 8'd0, 2'd0, 3199);
    frame_tick = 1; mf_tag = 2'd0; mf_found = 1;
    @(negedge clk);
    frame_tick = 0; mf_found = 0;
    chk("R9 priority", {sel_off, flags()}, {8'd3, 5'b10000});

    // R10 primary event ignored while locked
    do_op(1, 8'd99, 2'd0, 0);
    chk("R10 prim ignored", {sel_off, flags()}, {8'd3, 5'b10000});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule